// File: doc/BRIEF.md
# Privileged Control Register File

This block holds the privileged and hyperprivileged control state of one processor strand. Software-visible state is reached through a single port that is addressed by register number. Writes take effect on the clock edge. Reads are combinational. Five of the registers are stacks indexed by the current trap level: trap PC, trap next-PC, trap state, trap type and hyperprivileged trap state. An access to any of them uses entry TL-1.

The other registers hold scalar state:
- trap base
- processor state
- hyperprivileged state
- trap level
- primary and secondary MMU context
- partition id
- load/store unit control
- strand status
- hyperprivileged interrupt pending
- hyperprivileged trap base
- eight scratchpad words
- head and tail pointers for four interrupt queues

Some writes are masked or truncated. Reset loads fixed constants. The block continuously packs a translation-control word for the MMU. It also keeps a trap-level-zero interrupt request, which is re-evaluated on every write to the trap level.

Register numbers:

| Number | Register |
|---|---|
| 0 | trap PC stack |
| 1 | trap next-PC stack |
| 2 | trap state stack |
| 3 | trap type stack |
| 4 | trap base |
| 5 | processor state |
| 6 | TL |
| 7 | hyperprivileged state |
| 8 | hyperprivileged trap state stack |
| 9 | primary context |
| 10 | secondary context |
| 11 | partition id |
| 12 | LSU control |
| 13 | strand status |
| 14 | interrupt pending |
| 15 | hyperprivileged trap base |
| 16-23 | scratchpad |
| 24-31 | queue pointers |

Numbers 32 and above are not implemented.

Top module: `priv_ctl_regfile`

## Requirements
- R1: Registers 0, 1, 2, 3 and 8 are stacks of DEPTH entries (default 6). A read or write of one of them uses entry TL-1, and each entry of each stack is independent.
- R2: A write to register 4 (trap base) stores the data with bits 14:0 forced to zero.
- R3: A write to register 5 (processor state) keeps only bits 1, 2, 3, 4, 7:6, 8, 9 and 11, which is mask 0xBDE. All other bits read back as zero.
- R4: After reset:
  - register 7 (hyperprivileged state) reads 0x800;
  - register 13 (strand status) reads 0x50000;
  - every other implemented register reads 0;
  - the MMU word, the interrupt request and the error flag are all 0.
- R5: On every write to register 6 (TL), tlz_irq is updated on the following edge to (hpstate bit 0 AND new TL == 0 AND NOT hpstate bit 2). A write to any other register leaves tlz_irq unchanged.
- R6: mmu_ctl carries these fields, and all other bits are zero:

  | Bits | Content |
  |---|---|
  | 0 | hpstate bit 2 |
  | 1 | hpstate bit 5 |
  | 2 | pstate bit 2 |
  | 3 | pstate bit 3 |
  | 5:4 | LSU control bits 3:2 |
  | 15:8 | partition id bits 7:0 |
  | 18:16 | TL |
  | 47:32 | primary context bits 15:0 |
  | 63:48 | secondary context bits 15:0 |

- R7: Registers 16 to 31 (scratchpad and queue pointers) are plain 64-bit storage. TL stores data bits 2:0.
- R8: A read with rd_en or a write with wr_en to a register number of 32 or more sets acc_err for the following cycle. Such a write changes no state, and such a read returns 0.
- R9: An access to a stack register while TL is 0 or greater than DEPTH sets acc_err for the following cycle. The write is dropped and the read returns 0.
- R10: A write becomes visible on rd_data only after the clock edge. rd_data follows rd_num combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| wr_en | input | 1 | write strobe |
| wr_num | input | NUMW | register number for the write |
| wr_data | input | 64 | write data |
| rd_en | input | 1 | read strobe, used only for error reporting |
| rd_num | input | NUMW | register number for the read |
| rd_data | output | 64 | read data, combinational |
| mmu_ctl | output | 64 | packed translation-control word |
| tlz_irq | output | 1 | trap-level-zero interrupt request |
| acc_err | output | 1 | one-cycle access error flag |

## Verification
The bench walks TL through every value from 0 to 7 and writes a distinct pattern into each stack entry. A design that indexes with TL instead of TL-1, or that wraps at TL=0, would alias or clobber a neighbouring entry.

The mask checks write all ones to registers 4 and 5; a wrong mask leaks a stray bit. The full unimplemented range is swept, and storage is re-read afterwards; a design that decodes only the low number bits would overwrite a scratchpad.

The interrupt request is exercised under each of its three gating bits, and also across unrelated writes; a design that re-evaluates it on every cycle would lose it. The MMU word is compared against values chosen so that every field, truncated source bits included, differs from its neighbours.

// File: rtl/priv_ctl_regfile.sv
module priv_ctl_regfile #(
  parameter int DEPTH = 6,
  parameter int NUMW  = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [NUMW-1:0] wr_num,
  input  logic [63:0]     wr_data,
  input  logic            rd_en,
  input  logic [NUMW-1:0] rd_num,
  output logic [63:0]     rd_data,
  output logic [63:0]     mmu_ctl,
  output logic            tlz_irq,
  output logic            acc_err
);
  localparam logic [NUMW-1:0] N_TBA  = NUMW'(4);
  localparam logic [NUMW-1:0] N_PST  = NUMW'(5);
  localparam logic [NUMW-1:0] N_TL   = NUMW'(6);
  localparam logic [NUMW-1:0] N_HPS  = NUMW'(7);
  localparam logic [NUMW-1:0] N_HTS  = NUMW'(8);
  localparam logic [NUMW-1:0] N_PCTX = NUMW'(9);
  localparam logic [NUMW-1:0] N_SCTX = NUMW'(10);
  localparam logic [NUMW-1:0] N_PART = NUMW'(11);
  localparam logic [NUMW-1:0] N_LSU  = NUMW'(12);
  localparam logic [NUMW-1:0] N_SSR  = NUMW'(13);
  localparam logic [NUMW-1:0] N_HINT = NUMW'(14);
  localparam logic [NUMW-1:0] N_HTBA = NUMW'(15);
  localparam logic [NUMW-1:0] N_GP   = NUMW'(16);
  localparam logic [NUMW-1:0] N_END  = NUMW'(32);
  localparam logic [63:0] PST_KEEP = 64'hBDE;
  localparam logic [63:0] HPS_RST  = 64'h800;
  localparam logic [63:0] SSR_RST  = 64'h5_0000;
  localparam int IW = $clog2(DEPTH);

  logic [63:0] stk_q [5][DEPTH];
  logic [63:0] gp_q  [16];
  logic [63:0] tba_q, pst_q, hps_q, pctx_q, sctx_q, part_q, lsu_q, ssr_q, hint_q, htba_q;
  logic [2:0]  tl_q;
  logic        tlz_q, err_q;

  wire          tl_ok = (tl_q != 3'd0) && (int'(tl_q) <= DEPTH);
  wire [2:0]    tl_m1 = tl_q - 3'd1;
  wire [IW-1:0] idx   = tl_m1[IW-1:0];

  function automatic logic is_stk(input logic [NUMW-1:0] n);
    return (n < NUMW'(4)) || (n == N_HTS);
  endfunction

  function automatic logic [2:0] stk_sel(input logic [NUMW-1:0] n);
    return (n == N_HTS) ? 3'd4 : {1'b0, n[1:0]};
  endfunction

  function automatic logic bad(input logic [NUMW-1:0] n, input logic ok);
    return (n >= N_END) || (is_stk(n) && !ok);
  endfunction

  always_comb begin
    rd_data = '0;
    if (!bad(rd_num, tl_ok)) begin
      if (rd_num >= N_GP) rd_data = gp_q[rd_num[3:0]];
      else if (is_stk(rd_num)) rd_data = stk_q[stk_sel(rd_num)][idx];
      else begin
        case (rd_num)
          N_TBA:   rd_data = tba_q;
          N_PST:   rd_data = pst_q;
          N_TL:    rd_data = {61'd0, tl_q};
          N_HPS:   rd_data = hps_q;
          N_PCTX:  rd_data = pctx_q;
          N_SCTX:  rd_data = sctx_q;
          N_PART:  rd_data = part_q;
          N_LSU:   rd_data = lsu_q;
          N_SSR:   rd_data = ssr_q;
          N_HINT:  rd_data = hint_q;
          N_HTBA:  rd_data = htba_q;
          default: rd_data = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < 5; s++)
        for (int e = 0; e < DEPTH; e++) stk_q[s][e] <= '0;
      for (int g = 0; g < 16; g++) gp_q[g] <= '0;
      tba_q <= '0; pst_q <= '0; hps_q <= HPS_RST; pctx_q <= '0; sctx_q <= '0;
      part_q <= '0; lsu_q <= '0; ssr_q <= SSR_RST; hint_q <= '0; htba_q <= '0;
      tl_q <= '0; tlz_q <= 1'b0; err_q <= 1'b0;
    end else begin
      err_q <= (wr_en && bad(wr_num, tl_ok)) || (rd_en && bad(rd_num, tl_ok));
      if (wr_en && !bad(wr_num, tl_ok)) begin
        if (wr_num >= N_GP) gp_q[wr_num[3:0]] <= wr_data;
        else if (is_stk(wr_num)) stk_q[stk_sel(wr_num)][idx] <= wr_data;
        else begin
          case (wr_num)
            N_TBA:  tba_q  <= {wr_data[63:15], 15'd0};
            N_PST:  pst_q  <= wr_data & PST_KEEP;
            N_TL: begin
              tl_q  <= wr_data[2:0];
              tlz_q <= hps_q[0] && (wr_data[2:0] == 3'd0) && !hps_q[2];
            end
            N_HPS:  hps_q  <= wr_data;
            N_PCTX: pctx_q <= wr_data;
            N_SCTX: sctx_q <= wr_data;
            N_PART: part_q <= wr_data;
            N_LSU:  lsu_q  <= wr_data;
            N_SSR:  ssr_q  <= wr_data;
            N_HINT: hint_q <= wr_data;
            N_HTBA: htba_q <= wr_data;
            default: ;
          endcase
        end
      end
    end
  end

  assign mmu_ctl = {sctx_q[15:0], pctx_q[15:0], 13'd0, tl_q, part_q[7:0], 2'd0,
                    lsu_q[3:2], pst_q[3], pst_q[2], hps_q[5], hps_q[2]};
  assign tlz_irq = tlz_q;
  assign acc_err = err_q;
endmodule

// File: rtl/priv_ctl_regfile_chk.sv
module priv_ctl_regfile_chk #(
  parameter int NUMW = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [NUMW-1:0] wr_num,
  input logic [63:0]     wr_data,
  input logic            rd_en,
  input logic [NUMW-1:0] rd_num,
  input logic [63:0]     rd_data,
  input logic [63:0]     mmu_ctl,
  input logic            tlz_irq,
  input logic            acc_err
);
  localparam logic [NUMW-1:0] C_PST = NUMW'(5);
  localparam logic [NUMW-1:0] C_TL  = NUMW'(6);
  localparam logic [NUMW-1:0] C_END = NUMW'(32);

  assert_pstate_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_num == C_PST) |-> ((rd_data & ~64'hBDE) == 64'd0));

  assert_tlz_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_num == C_TL) |=> $stable(tlz_irq));

  assert_mmu_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mmu_ctl[31:19] == 13'd0) && (mmu_ctl[7:6] == 2'd0));

  assert_mmu_tl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_num == C_TL) |=> (mmu_ctl[18:16] == $past(wr_data[2:0])));

  assert_bad_wr_noeffect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_num >= C_END) |=> ($stable(mmu_ctl) && $stable(tlz_irq) && acc_err));

  assert_bad_rd_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_num >= C_END) |-> (rd_data == 64'd0));

  assert_bad_rd_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_num >= C_END) |=> acc_err);
endmodule

bind priv_ctl_regfile priv_ctl_regfile_chk #(.NUMW(NUMW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_num(wr_num), .wr_data(wr_data),
  .rd_en(rd_en), .rd_num(rd_num), .rd_data(rd_data), .mmu_ctl(mmu_ctl),
  .tlz_irq(tlz_irq), .acc_err(acc_err));

// File: tb/priv_ctl_regfile_tb_top.sv
module priv_ctl_regfile_tb_top;
  localparam int DEPTH = 6;
  localparam int NUMW  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [NUMW-1:0] wr_num = '0, rd_num = '0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data, mmu_ctl;
  logic tlz_irq, acc_err;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  priv_ctl_regfile #(.DEPTH(DEPTH), .NUMW(NUMW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_num(wr_num), .wr_data(wr_data),
    .rd_en(rd_en), .rd_num(rd_num), .rd_data(rd_data), .mmu_ctl(mmu_ctl),
    .tlz_irq(tlz_irq), .acc_err(acc_err));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int n, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_num = NUMW'(n); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input string tag, input int n, input logic [63:0] exp);
    rd_num = NUMW'(n); rd_en = 1'b1;
    #1;
    chk(tag, rd_data, exp);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  function automatic logic [63:0] pat(input int s, input int t);
    return (64'h1357_9BDF_0000_0000 * 64'(s + 1)) ^ 64'(t * 16'h0101);
  endfunction

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd1, 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 reset values
    for (int n = 4; n < 32; n++)
      rd("R4 reset", n, (n == 7) ? 64'h800 : (n == 13) ? 64'h5_0000 : 64'd0);
    chk("R4 mmu_ctl", mmu_ctl, 64'd0);
    chk("R4 tlz_irq", {63'd0, tlz_irq}, 64'd0);
    chk("R4 acc_err", {63'd0, acc_err}, 64'd0);

    // R9 stack access at TL=0
    wr(0, 64'hDEAD);
    chk("R9 err tl0 write", {63'd0, acc_err}, 64'd1);
    rd("R9 read zero tl0", 2, 64'd0);
    chk("R9 err tl0 read", {63'd0, acc_err}, 64'd1);

    // R1 fill every entry of every stack
    for (int t = 1; t <= DEPTH; t++) begin
      wr(6, 64'(t));
      for (int s = 0; s < 5; s++) wr((s == 4) ? 8 : s, pat(s, t));
    end
    for (int t = DEPTH; t >= 1; t--) begin
      wr(6, 64'(t));
      rd("R7 tl readback", 6, 64'(t));
      for (int s = 0; s < 5; s++) rd("R1 stack entry", (s == 4) ? 8 : s, pat(s, t));
      chk("R1 no err", {63'd0, acc_err}, 64'd0);
    end
    wr(6, 64'hFFFF_FFFF_FFFF_FFF7);
    rd("R7 tl truncated", 6, 64'd7);
    wr(1, 64'h1);
    chk("R9 err tl7 write", {63'd0, acc_err}, 64'd1);
    rd("R9 read zero tl7", 1, 64'd0);
    wr(6, 64'd1);
    rd("R1 tl1 intact after tl7", 1, pat(1, 1));
    wr(6, 64'd0);
    wr(8, 64'h5);
    wr(6, 64'd1);
    rd("R9 tl0 write dropped", 8, pat(4, 1));

    // R2, R3 masks
    wr(4, '1);
    rd("R2 tba mask", 4, 64'hFFFF_FFFF_FFFF_8000);
    wr(5, '1);
    rd("R3 pstate mask", 5, 64'hBDE);
    wr(5, 64'h421);
    rd("R3 pstate mask2", 5, 64'h0);

    // R7 plain storage
    for (int n = 16; n < 32; n++) wr(n, 64'hA5A5_0000_0000_0000 | 64'(n * 77));
    for (int n = 9; n < 16; n++) if (n != 13) wr(n, 64'hC3C3_0000_0000_0000 | 64'(n));
    for (int n = 16; n < 32; n++) rd("R7 storage", n, 64'hA5A5_0000_0000_0000 | 64'(n * 77));
    rd("R7 hintp", 14, 64'hC3C3_0000_0000_000E);
    rd("R7 htba", 15, 64'hC3C3_0000_0000_000F);

    // R8 unimplemented numbers
    for (int n = 32; n < 64; n++) begin
      wr(n, '1);
      chk("R8 err write", {63'd0, acc_err}, 64'd1);
      rd("R8 read zero", n, 64'd0);
      chk("R8 err read", {63'd0, acc_err}, 64'd1);
    end
    for (int n = 16; n < 32; n++) rd("R8 storage intact", n, 64'hA5A5_0000_0000_0000 | 64'(n * 77));
    @(negedge clk);
    chk("R8 err clears", {63'd0, acc_err}, 64'd0);

    // R6 mmu word
    wr(7, 64'h824);
    wr(5, 64'hC);
    wr(12, 64'hF);
    wr(11, 64'h1AB);
    wr(9, 64'h5_1234);
    wr(10, 64'h7_BEEF);
    wr(6, 64'd5);
    chk("R6 mmu word", mmu_ctl, 64'hBEEF_1234_0005_AB3F);
    wr(7, 64'h800);
    wr(12, 64'h4);
    chk("R6 mmu word2", mmu_ctl, 64'hBEEF_1234_0005_AB1C);

    // R5 trap-level-zero request
    wr(7, 64'h801);
    wr(6, 64'd0);
    chk("R5 raise", {63'd0, tlz_irq}, 64'd1);
    wr(20, 64'h0);
    chk("R5 hold across other write", {63'd0, tlz_irq}, 64'd1);
    wr(6, 64'd2);
    chk("R5 clear tl nonzero", {63'd0, tlz_irq}, 64'd0);
    wr(7, 64'h805);
    wr(6, 64'd0);
    chk("R5 hpriv blocks", {63'd0, tlz_irq}, 64'd0);
    wr(7, 64'h800);
    wr(6, 64'd0);
    chk("R5 tlz off", {63'd0, tlz_irq}, 64'd0);

    // R10 write visible only after the edge
    @(negedge clk);
    wr_en = 1'b1; wr_num = NUMW'(16); wr_data = 64'h0123_4567_89AB_CDEF; rd_num = NUMW'(16);
    #1;
    chk("R10 old before edge", rd_data, 64'hA5A5_0000_0000_0000 | 64'(16 * 77));
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    chk("R10 new after edge", rd_data, 64'h0123_4567_89AB_CDEF);

    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule